// File: doc/BRIEF.md
# Bit-Plane Pixel Reorderer with Gray Decode

This block sits behind the deserializer of one sensor pixel lane. The lane delivers a stripe of 20 rows, each row holding the results of 40 column converters. Within a row the converters' results are not sent one after another: the lowest bit of every converter comes first, then the next bit of every converter, up to the top bit. A 40-bit check word closes each row. The block gathers these bit planes back into whole pixel words and turns each word from Gray code into plain binary. It then hands the pixels downstream in column order, tagged with row and column, over a valid/ready stream.

Two row buffers alternate, so one row can drain while the next row's bit planes are written. Stream faults are handled, not hidden. A check word that disagrees with the data marks that row's pixels as bad. A frame marker in the middle of a stripe throws away the partial row and starts again. A row that finds both buffers still occupied is dropped. Each of the three faults also sets a flag that stays set until reset.

The receive side is a three-state machine. RX_IDLE waits for a frame marker and moves to RX_PLANES when one arrives. RX_PLANES collects data bits and moves to RX_CHECK after the top plane's last column. RX_CHECK compares the check bits and, at the row's last column, returns to RX_PLANES, or to RX_IDLE after row 19. From RX_PLANES or RX_CHECK, a frame marker always moves the machine to RX_PLANES. The send side has two states. TX_WAIT moves to TX_SEND once the next buffer is full. TX_SEND moves back to TX_WAIT after the handshake on column 39.

Top module: `bit_plane_reorder`

## Requirements
- R1: After reset, out_valid is low and err_check, err_frame and err_ovf are all low.
- R2: A bit is taken only in a cycle with in_valid high. A row is W data planes (W=9 when cfg_wide is 0, W=10 when it is 1), plane 0 (the least significant bit) first. Within each plane the 40 bits run from column 0 to column 39. The 40 check bits follow, also from column 0 upward.
- R3: Each output pixel is the binary value of the row's Gray-coded word (binary bit i = XOR of Gray bits i and above), zero-extended to 10 bits in 9-bit mode.
- R4: cfg_wide is sampled with the frame-start bit and sets the plane count for the whole stripe. A 9-bit stripe read from buffers that last held 10-bit data still decodes correctly.
- R5: The pixels of a row leave with out_col running from 0 to 39 and out_row giving the row index 0..19. out_last is high only on row 19, column 39.
- R6: Check bit c must equal the XOR of column c's W Gray bits. A mismatch in any column sets out_bad on all 40 pixels of that row and sets the sticky err_check.
- R7: When each row drains before the next one ends, no row is lost and err_ovf stays low.
- R8: If a row's first bit arrives while both buffers are still full, the whole row is discarded and err_ovf is set and stays set.
- R9: A frame marker (in_sof with in_valid) that arrives outside RX_IDLE discards the partial row and sets the sticky err_frame. That bit becomes row 0, plane 0, column 0 of a new stripe.
- R10: In RX_IDLE, both before the first frame marker and after row 19 completes, bits without a frame marker are ignored and produce no output.
- R11: While out_valid is high and out_ready is low, out_valid and all output fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 10-bit words, 0 selects 9-bit words |
| in_valid | input | 1 | A lane bit is present this cycle |
| in_bit | input | 1 | Lane bit |
| in_sof | input | 1 | This bit is the first bit of a stripe |
| out_valid | output | 1 | A pixel is offered |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pix | output | 10 | Binary pixel value |
| out_row | output | 5 | Row index inside the stripe |
| out_col | output | 6 | Column index inside the row |
| out_last | output | 1 | Last pixel of the stripe |
| out_bad | output | 1 | The row failed its check word |
| err_check | output | 1 | Sticky: some row failed its check word |
| err_frame | output | 1 | Sticky: a frame marker arrived mid-stripe |
| err_ovf | output | 1 | Sticky: a row was dropped because both buffers were full |

## Verification
Stripes use per-row values that put 0 and the full-scale code in the end columns. A transposition error or a wrong Gray stage therefore shows up as a wrong pixel, not as a shuffled but plausible one. A 9-bit stripe with a stalling consumer tests the plane ordering and output holding. A 10-bit stripe with gaps in in_valid, followed by a 9-bit stripe, separates the width latch from stale top bits left in the buffers. One stripe has a single flipped check bit, which shows whether out_bad follows the row and only that row. A stripe cut off mid-row by a new frame marker, and a stripe sent into a consumer that never accepts, show which rows survive a framing fault and an overflow. Stray bits in RX_IDLE must yield nothing.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_PLANES = 2'd1,
        RX_CHECK  = 2'd2
    } rx_state_t;

    typedef enum logic {
        TX_WAIT = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

endpackage

// File: rtl/bpr_rx.sv
module bpr_rx
    import bpr_pkg::*;
#(
    parameter int N_COL = 40,
    parameter int N_ROW = 20,
    parameter int W_MAX = 10,
    parameter int CW    = 6,
    parameter int RW    = 5,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wide,
    input  logic          in_valid,
    input  logic          in_bit,
    input  logic          in_sof,
    input  logic [1:0]    bank_full,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [CW-1:0] wr_col,
    output logic [PW-1:0] wr_plane,
    output logic          wr_bit,
    output logic          commit,
    output logic          commit_bank,
    output logic [RW-1:0] commit_row,
    output logic          commit_bad,
    output logic          commit_wide,
    output logic          err_check,
    output logic          err_frame,
    output logic          err_ovf
);

    localparam logic [CW-1:0] COL_END = CW'(N_COL - 1);
    localparam logic [RW-1:0] ROW_END = RW'(N_ROW - 1);

    rx_state_t        st, st_nx;
    logic [CW-1:0]    col;
    logic [PW-1:0]    plane;
    logic [RW-1:0]    row;
    logic [N_COL-1:0] par;
    logic             row_bad, drop_q, wb, wide;

    logic [PW-1:0] plane_top;
    logic          sof_ev, take_data, take_chk, row_start, drop_eff, mism, row_done;
    logic [CW-1:0] pc;
    logic [PW-1:0] pp;

    always_comb begin
        plane_top = wide ? PW'(W_MAX - 1) : PW'(W_MAX - 2);
        sof_ev    = in_valid && in_sof;
        take_data = sof_ev || (in_valid && st == RX_PLANES);
        take_chk  = in_valid && !in_sof && st == RX_CHECK;
        pc        = sof_ev ? '0 : col;
        pp        = sof_ev ? '0 : plane;
        row_start = take_data && pc == '0 && pp == '0;
        drop_eff  = row_start ? bank_full[wb] : drop_q;
        mism      = in_bit ^ par[col];
        row_done  = take_chk && col == COL_END;
    end

    // write port and row commit toward the buffers
    always_comb begin
        wr_en       = take_data && !drop_eff;
        wr_bank     = wb;
        wr_col      = pc;
        wr_plane    = pp;
        wr_bit      = in_bit;
        commit      = row_done && !drop_q;
        commit_bank = wb;
        commit_row  = row;
        commit_bad  = row_bad | mism;
        commit_wide = wide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE: begin
                if (sof_ev) st_nx = RX_PLANES;
            end
            RX_PLANES: begin
                if (take_data && pc == COL_END && pp == plane_top) st_nx = RX_CHECK;
            end
            RX_CHECK: begin
                if (sof_ev)        st_nx = RX_PLANES;
                else if (row_done) st_nx = (row == ROW_END) ? RX_IDLE : RX_PLANES;
            end
            default: st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col       <= '0;
            plane     <= '0;
            row       <= '0;
            par       <= '0;
            row_bad   <= 1'b0;
            drop_q    <= 1'b0;
            wb        <= 1'b0;
            wide      <= 1'b0;
            err_check <= 1'b0;
            err_frame <= 1'b0;
            err_ovf   <= 1'b0;
        end else begin
            if (sof_ev) begin
                wide <= cfg_wide;
                row  <= '0;
                if (st != RX_IDLE) err_frame <= 1'b1;
            end
            if (take_data) begin
                par[pc] <= (pp == '0) ? in_bit : (par[pc] ^ in_bit);
                if (pc == COL_END) begin
                    col   <= '0;
                    plane <= (pp == plane_top) ? '0 : pp + 1'b1;
                end else begin
                    col   <= pc + 1'b1;
                    plane <= pp;
                end
                if (row_start) begin
                    drop_q  <= bank_full[wb];
                    row_bad <= 1'b0;
                    if (bank_full[wb]) err_ovf <= 1'b1;
                end
            end
            if (take_chk) begin
                row_bad <= row_bad | mism;
                col     <= (col == COL_END) ? '0 : col + 1'b1;
                if (row_done) begin
                    row <= (row == ROW_END) ? '0 : row + 1'b1;
                    if (!drop_q) begin
                        wb <= ~wb;
                        if (row_bad | mism) err_check <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: a row is only committed into a buffer that the drain side has freed
    a_r8_commit_free: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !bank_full[commit_bank]);

    // R8: the overflow flag never clears by itself
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);

endmodule

// File: rtl/bpr_rowbuf.sv
module bpr_rowbuf #(
    parameter int N_COL = 40,
    parameter int W_MAX = 10,
    parameter int CW    = 6,
    parameter int RW    = 5,
    parameter int PW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [CW-1:0]    wr_col,
    input  logic [PW-1:0]    wr_plane,
    input  logic             wr_bit,
    input  logic             commit,
    input  logic             commit_bank,
    input  logic [RW-1:0]    commit_row,
    input  logic             commit_bad,
    input  logic             commit_wide,
    input  logic             release_bank,
    input  logic             rd_bank,
    input  logic [CW-1:0]    rd_col,
    output logic [1:0]       bank_full,
    output logic [W_MAX-1:0] rd_word,
    output logic [RW-1:0]    rd_row,
    output logic             rd_bad,
    output logic             rd_wide
);

    logic [W_MAX-1:0] mem [2][N_COL];
    logic [RW-1:0]    row_tag [2];
    logic [1:0]       bad_tag, wide_tag;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_col][wr_plane] <= wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full  <= 2'b00;
            bad_tag    <= 2'b00;
            wide_tag   <= 2'b00;
            row_tag[0] <= '0;
            row_tag[1] <= '0;
        end else begin
            if (release_bank) bank_full[rd_bank] <= 1'b0;
            if (commit) begin
                bank_full[commit_bank] <= 1'b1;
                row_tag[commit_bank]   <= commit_row;
                bad_tag[commit_bank]   <= commit_bad;
                wide_tag[commit_bank]  <= commit_wide;
            end
        end
    end

    always_comb begin
        rd_word = mem[rd_bank][rd_col];
        rd_row  = row_tag[rd_bank];
        rd_bad  = bad_tag[rd_bank];
        rd_wide = wide_tag[rd_bank];
    end

    // R7: the receive side never writes into a buffer still waiting to drain
    a_r7_write_free: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bank_full[wr_bank]);

endmodule

// File: rtl/bpr_tx.sv
module bpr_tx
    import bpr_pkg::*;
#(
    parameter int N_COL = 40,
    parameter int N_ROW = 20,
    parameter int W_MAX = 10,
    parameter int CW    = 6,
    parameter int RW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bank_full,
    input  logic [W_MAX-1:0] rd_word,
    input  logic [RW-1:0]    rd_row,
    input  logic             rd_bad,
    input  logic             rd_wide,
    output logic             rd_bank,
    output logic [CW-1:0]    rd_col,
    output logic             release_bank,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [W_MAX-1:0] out_pix,
    output logic [RW-1:0]    out_row,
    output logic [CW-1:0]    out_col,
    output logic             out_last,
    output logic             out_bad
);

    localparam logic [CW-1:0] COL_END = CW'(N_COL - 1);
    localparam logic [RW-1:0] ROW_END = RW'(N_ROW - 1);

    tx_state_t        st, st_nx;
    logic [CW-1:0]    col;
    logic             bank;
    logic             fire;
    logic [W_MAX-1:0] g, b;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_WAIT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_WAIT: if (bank_full[bank]) st_nx = TX_SEND;
            TX_SEND: if (fire && col == COL_END) st_nx = TX_WAIT;
            default: st_nx = TX_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col  <= '0;
            bank <= 1'b0;
        end else if (fire) begin
            if (col == COL_END) begin
                col  <= '0;
                bank <= ~bank;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Gray to binary, top bit masked in narrow mode
    always_comb begin
        g = rd_word;
        if (!rd_wide) g[W_MAX-1] = 1'b0;
        b[W_MAX-1] = g[W_MAX-1];
        for (int i = W_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    end

    always_comb begin
        out_valid    = (st == TX_SEND);
        fire         = out_valid && out_ready;
        release_bank = fire && col == COL_END;
        rd_bank      = bank;
        rd_col       = col;
        out_pix      = b;
        out_row      = rd_row;
        out_col      = col;
        out_bad      = rd_bad;
        out_last     = out_valid && rd_row == ROW_END && col == COL_END;
    end

    // R11: an offered pixel is held until taken
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_row)
                                   && $stable(out_col) && $stable(out_bad));

    // R5: the handshake on the last column ends the row
    a_r5_row_end: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_col == COL_END |=> !out_valid);

endmodule

// File: rtl/bit_plane_reorder.sv
module bit_plane_reorder #(
    parameter int N_COL = 40,
    parameter int N_ROW = 20,
    parameter int W_MAX = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wide,
    input  logic                       in_valid,
    input  logic                       in_bit,
    input  logic                       in_sof,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [W_MAX-1:0]           out_pix,
    output logic [$clog2(N_ROW)-1:0]   out_row,
    output logic [$clog2(N_COL)-1:0]   out_col,
    output logic                       out_last,
    output logic                       out_bad,
    output logic                       err_check,
    output logic                       err_frame,
    output logic                       err_ovf
);

    localparam int CW = $clog2(N_COL);
    localparam int RW = $clog2(N_ROW);
    localparam int PW = $clog2(W_MAX);

    logic          wr_en, wr_bank, wr_bit;
    logic [CW-1:0] wr_col, rd_col;
    logic [PW-1:0] wr_plane;
    logic          commit, commit_bank, commit_bad, commit_wide;
    logic [RW-1:0] commit_row, rd_row;
    logic [1:0]    bank_full;
    logic          release_bank, rd_bank, rd_bad, rd_wide;
    logic [W_MAX-1:0] rd_word;

    bpr_rx #(.N_COL(N_COL), .N_ROW(N_ROW), .W_MAX(W_MAX), .CW(CW), .RW(RW), .PW(PW)) u_rx (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof),
        .bank_full(bank_full),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_plane(wr_plane), .wr_bit(wr_bit),
        .commit(commit), .commit_bank(commit_bank), .commit_row(commit_row),
        .commit_bad(commit_bad), .commit_wide(commit_wide),
        .err_check(err_check), .err_frame(err_frame), .err_ovf(err_ovf)
    );

    bpr_rowbuf #(.N_COL(N_COL), .W_MAX(W_MAX), .CW(CW), .RW(RW), .PW(PW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_plane(wr_plane), .wr_bit(wr_bit),
        .commit(commit), .commit_bank(commit_bank), .commit_row(commit_row),
        .commit_bad(commit_bad), .commit_wide(commit_wide),
        .release_bank(release_bank), .rd_bank(rd_bank), .rd_col(rd_col),
        .bank_full(bank_full), .rd_word(rd_word), .rd_row(rd_row),
        .rd_bad(rd_bad), .rd_wide(rd_wide)
    );

    bpr_tx #(.N_COL(N_COL), .N_ROW(N_ROW), .W_MAX(W_MAX), .CW(CW), .RW(RW)) u_tx (
        .clk(clk), .rst_n(rst_n), .bank_full(bank_full),
        .rd_word(rd_word), .rd_row(rd_row), .rd_bad(rd_bad), .rd_wide(rd_wide),
        .rd_bank(rd_bank), .rd_col(rd_col), .release_bank(release_bank),
        .out_ready(out_ready), .out_valid(out_valid), .out_pix(out_pix),
        .out_row(out_row), .out_col(out_col), .out_last(out_last), .out_bad(out_bad)
    );

endmodule

// File: tb/sim_bit_plane_reorder.sv
module sim_bit_plane_reorder;

    localparam int N_COL = 40;
    localparam int N_ROW = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, cfg_wide = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_sof = 1'b0;
    logic       out_ready = 1'b0;
    logic       out_valid, out_last, out_bad, err_check, err_frame, err_ovf;
    logic [9:0] out_pix;
    logic [4:0] out_row;
    logic [5:0] out_col;

    bit_plane_reorder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .in_valid(in_valid), .in_bit(in_bit), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_row(out_row), .out_col(out_col), .out_last(out_last), .out_bad(out_bad),
        .err_check(err_check), .err_frame(err_frame), .err_ovf(err_ovf)
    );

    typedef struct packed {
        logic [9:0] pix;
        logic [4:0] row;
        logic [5:0] col;
        logic       last;
        logic       bad;
    } item_t;

    item_t      exp_q[$];
    item_t      e_it, g_it;
    int         total = 0, bad = 0, cyc = 0, ready_mode = 0, nbits = 0;
    bit         gap_en = 0, finished = 0;
    logic [9:0] vals [N_COL];

    task automatic chk(input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [9:0] gray(input logic [9:0] v);
        return v ^ (v >> 1);
    endfunction

    // monitor: picks out_ready, then compares accepted pixels with the scoreboard
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 0;
            default: out_ready = 1'b0;
        endcase
        #1;
        if (rst_n && out_valid && out_ready) begin
            g_it = '{pix: out_pix, row: out_row, col: out_col, last: out_last, bad: out_bad};
            if (exp_q.size() == 0) begin
                chk(0, $sformatf("R5 R10 unexpected pixel row=%0d col=%0d pix=%0d, expected none",
                                 out_row, out_col, out_pix));
            end else begin
                e_it = exp_q.pop_front();
                chk(g_it == e_it, $sformatf(
                    "R3 R5 R6 got pix=%0d row=%0d col=%0d last=%0b bad=%0b exp pix=%0d row=%0d col=%0d last=%0b bad=%0b",
                    g_it.pix, g_it.row, g_it.col, g_it.last, g_it.bad,
                    e_it.pix, e_it.row, e_it.col, e_it.last, e_it.bad));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    task automatic send_bit(input logic b, input logic sof);
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = b;
        in_sof   = sof;
        nbits++;
        if (gap_en && (nbits % 7) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
            in_bit   = ~b;
        end
    endtask

    task automatic fill_vals(input int seed, input int r, input int nplanes);
        int mask = (1 << nplanes) - 1;
        for (int c = 0; c < N_COL; c++)
            vals[c] = 10'((r * 37 + c * 11 + seed * 53 + r * c) & mask);
        vals[0]       = (r % 2 == 0) ? 10'd0 : 10'(mask);
        vals[N_COL-1] = 10'(mask);
    endtask

    task automatic push_row(input int r, input bit badf);
        for (int c = 0; c < N_COL; c++)
            exp_q.push_back('{pix: vals[c], row: 5'(r), col: 6'(c),
                              last: (r == N_ROW - 1 && c == N_COL - 1), bad: badf});
    endtask

    task automatic send_row(input int nplanes, input bit sof_first, input int corrupt_col, input int limit);
        int         n = 0;
        logic [9:0] g;
        logic       cb;
        for (int p = 0; p < nplanes; p++) begin
            for (int c = 0; c < N_COL; c++) begin
                if (n == limit) return;
                g = gray(vals[c]);
                send_bit(g[p], sof_first && n == 0);
                n++;
            end
        end
        for (int c = 0; c < N_COL; c++) begin
            if (n == limit) return;
            g  = gray(vals[c]);
            cb = ^g;
            if (c == corrupt_col) cb = ~cb;
            send_bit(cb, 1'b0);
            n++;
        end
    endtask

    task automatic send_stripe(input int seed, input int nplanes, input logic wide,
                               input int bad_row, input int bad_col, input int push_upto);
        cfg_wide = wide;
        for (int r = 0; r < N_ROW; r++) begin
            fill_vals(seed, r, nplanes);
            if (r < push_upto) push_row(r, r == bad_row);
            send_row(nplanes, r == 0, (r == bad_row) ? bad_col : -1, 1000000);
        end
        idle(1);
    endtask

    task automatic wait_drain(input string tag);
        int k = 0;
        while (exp_q.size() != 0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, $sformatf("%s pixels still expected=%0d, expected 0", tag, exp_q.size()));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_flags(input string tag, input logic ec, input logic ef, input logic eo);
        chk({err_check, err_frame, err_ovf} == {ec, ef, eo},
            $sformatf("%s flags check/frame/ovf=%b%b%b, expected %b%b%b",
                      tag, err_check, err_frame, err_ovf, ec, ef, eo));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog: run still busy, expected completion");
            finish_up();
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(out_valid == 1'b0, $sformatf("R1 out_valid=%0b, expected 0", out_valid));
        chk_flags("R1", 1'b0, 1'b0, 1'b0);

        // R10 + R2 + R3 + R5 + R11: stray bits, then a 9-bit stripe with a stalling consumer
        ready_mode = 1;
        gap_en     = 0;
        for (int i = 0; i < 50; i++) send_bit(1'(i % 3 == 0), 1'b0);
        idle(5);
        chk(out_valid == 1'b0, $sformatf("R10 out_valid=%0b after stray bits, expected 0", out_valid));
        send_stripe(1, 9, 1'b0, -1, -1, N_ROW);
        for (int i = 0; i < 40; i++) send_bit(1'(i % 2), 1'b0);   // R10: after row 19
        idle(1);
        wait_drain("R2 R5 R10");
        chk_flags("R7", 1'b0, 1'b0, 1'b0);

        // R4 + R2: 10-bit stripe with gaps in in_valid
        ready_mode = 0;
        gap_en     = 1;
        send_stripe(2, 10, 1'b1, -1, -1, N_ROW);
        wait_drain("R4 R2");
        chk_flags("R4 R7", 1'b0, 1'b0, 1'b0);

        // R4 + R6: 9-bit stripe on buffers that held 10-bit words, one bad check bit
        gap_en     = 0;
        ready_mode = 1;
        send_stripe(3, 9, 1'b0, 3, 5, N_ROW);
        wait_drain("R4 R6");
        chk_flags("R6", 1'b1, 1'b0, 1'b0);

        // R9: frame marker mid-row discards the partial row
        do_reset();
        ready_mode = 0;
        cfg_wide   = 1'b0;
        for (int r = 0; r < 2; r++) begin
            fill_vals(4, r, 9);
            push_row(r, 1'b0);
            send_row(9, r == 0, -1, 1000000);
        end
        fill_vals(4, 2, 9);
        send_row(9, 1'b0, -1, 100);
        send_stripe(5, 9, 1'b0, -1, -1, N_ROW);
        wait_drain("R9");
        chk_flags("R9", 1'b0, 1'b1, 1'b0);

        // R8 + R11: consumer never ready, only two rows fit
        do_reset();
        ready_mode = 2;
        send_stripe(6, 9, 1'b0, -1, -1, 2);
        idle(3);
        chk_flags("R8", 1'b0, 1'b0, 1'b1);
        chk(out_valid == 1'b1 && out_row == 5'd0 && out_col == 6'd0,
            $sformatf("R11 stalled valid=%0b row=%0d col=%0d, expected 1 0 0", out_valid, out_row, out_col));
        ready_mode = 0;
        wait_drain("R8 R11");
        chk_flags("R8", 1'b0, 1'b0, 1'b1);

        finish_up();
    end

endmodule